// File: doc/BRIEF.md
# Expansion RAM Bank Mapper

This block sits between a CPU's 16-bit address bus and two 64 KB DRAM banks, a base bank and an expansion bank. The CPU loads a 3-bit mapping code with an I/O write. From that code, each of the four 16 KB address slots is placed on one 16 KB bank of either the base or the expansion RAM. The block drives the DRAM's top two address bits, and it routes the incoming column strobe to exactly one of the two banks.

Only CPU cycles are remapped. Video and other non-CPU cycles pass the address through unchanged and always use the base bank. An external RAM-disable line keeps the expansion strobe off, so an outside memory can take over those accesses. The bank choice is fixed when a strobe begins and does not change until that strobe ends.

Top module: `ram_bank_mapper`

## Requirements
- R1: On a clock edge where `io_wr`=1, `cpu_a15`=0, `data_in[7]`=1 and `data_in[6]`=1, the code register takes `data_in[2:0]`. Bits 5:3 (the page number) do not affect the mapping, and the new code applies from the next cycle.
- R2: The code register keeps its value when `io_wr`=0 (an I/O read of the same port), when `cpu_a15`=1, or when `data_in[7:6]` is not 2'b11.
- R3: A synchronous active-high `rst` clears the code to 0. Code 0 maps slot s (s = {`cpu_a15`,`cpu_a14`}) to base bank s for every slot.
- R4: Code 1 maps slots 0–2 to base banks 0–2 and slot 3 to expansion bank 3.
- R5: Code 2 maps slot s to expansion bank s for all four slots.
- R6: Code 3 maps slot 0 to base 0, slot 1 to base 3, slot 2 to base 2 and slot 3 to expansion 3.
- R7: Codes 4–7 map slot 1 to expansion bank b, where b = code[1:0]. The other slots stay on their own base banks.
- R8: During a CPU cycle, {`map_a15`,`map_a14`} equals the selected bank number in the same cycle as the address, with no register delay.
- R9: When `cpu_cycle`=0, {`map_a15`,`map_a14`} equals {`cpu_a15`,`cpu_a14`} and a strobe that starts then goes to `cas_base`.
- R10: When `ram_dis`=1 as a strobe starts, `cas_exp` stays low and `cas_base` carries the strobe. The address is still remapped.
- R11: While `cas_in`=1, exactly one of `cas_base` and `cas_exp` is 1. While `cas_in`=0, both are 0.
- R12: The strobe target chosen in the first cycle of `cas_in` is held until `cas_in` falls, whatever the address, `cpu_cycle` or `ram_dis` do in the meantime.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_a15 | input | 1 | CPU address bit 15 |
| cpu_a14 | input | 1 | CPU address bit 14 |
| data_in | input | 8 | CPU data bus |
| io_wr | input | 1 | I/O write strobe, active high |
| cpu_cycle | input | 1 | 1 when the current memory cycle belongs to the CPU |
| ram_dis | input | 1 | External RAM disable, active high |
| cas_in | input | 1 | Incoming column strobe, active high |
| map_a15 | output | 1 | Remapped DRAM address bit 15 |
| map_a14 | output | 1 | Remapped DRAM address bit 14 |
| cas_base | output | 1 | Column strobe to the base bank |
| cas_exp | output | 1 | Column strobe to the expansion bank |

## Verification
The address outputs follow the address in the same cycle. A code write becomes visible one clock edge after it is sampled. A strobe target is fixed at the edge that ends the strobe's first cycle. The bench drives inputs just after each falling edge and keeps a behavioural model that it updates at each rising edge. At every falling edge it compares all four outputs with that model, so combinational results are checked in the cycle they are driven and registered results in the cycle after their edge. Each phase tags its checks with the requirement it targets.

// File: rtl/ram_map_pkg.sv
package ram_map_pkg;

    localparam int CODE_W = 3;
    localparam int SLOT_W = 2;
    localparam int DATA_W = 8;
    localparam int KEY_HI = 7;
    localparam int KEY_LO = 6;

    typedef logic [CODE_W-1:0] map_code_t;
    typedef logic [SLOT_W-1:0] slot_t;

    typedef enum logic [CODE_W-1:0] {
        MAP_FLAT    = 3'd0,
        MAP_TOP_EXP = 3'd1,
        MAP_ALL_EXP = 3'd2,
        MAP_MIXED   = 3'd3
    } map_kind_e;

    typedef struct packed {
        logic  exp;
        slot_t bank;
    } slot_map_t;

    function automatic slot_map_t decode_slot(input map_code_t code, input slot_t slot);
        slot_map_t r;
        r.exp  = 1'b0;
        r.bank = slot;
        if (code[CODE_W-1]) begin
            if (slot == 2'd1) begin
                r.exp  = 1'b1;
                r.bank = code[SLOT_W-1:0];
            end
        end else begin
            case (map_kind_e'(code))
                MAP_TOP_EXP: r.exp = (slot == 2'd3);
                MAP_ALL_EXP: r.exp = 1'b1;
                MAP_MIXED: begin
                    if (slot == 2'd1) r.bank = 2'd3;
                    r.exp = (slot == 2'd3);
                end
                default: r.exp = 1'b0;
            endcase
        end
        return r;
    endfunction

endpackage

// File: rtl/map_code_reg.sv
module map_code_reg
    import ram_map_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              io_wr,
    input  logic              cpu_a15,
    input  logic [DATA_W-1:0] data_in,
    output map_code_t         code
);

    map_code_t code_q;
    logic      write_hit;

    assign write_hit = io_wr && !cpu_a15 && data_in[KEY_HI] && data_in[KEY_LO];

    always_ff @(posedge clk) begin
        if (rst)            code_q <= '0;
        else if (write_hit) code_q <= data_in[CODE_W-1:0];
    end

    assign code = code_q;

    AST_CODE_CLEARED: assert property (@(posedge clk) rst |=> (code_q == '0)); // R3
    AST_CODE_LOADED: assert property (@(posedge clk) disable iff (rst)
        write_hit |=> (code_q == $past(data_in[CODE_W-1:0]))); // R1
    AST_CODE_KEPT: assert property (@(posedge clk) disable iff (rst)
        !write_hit |=> $stable(code_q)); // R2

endmodule

// File: rtl/slot_remap.sv
module slot_remap
    import ram_map_pkg::*;
(
    input  logic      cpu_cycle,
    input  slot_t     slot_in,
    input  map_code_t code,
    output slot_t     slot_out,
    output logic      use_exp
);

    slot_map_t sel;

    always_comb begin
        sel = decode_slot(code, slot_in);
        if (cpu_cycle) begin
            slot_out = sel.bank;
            use_exp  = sel.exp;
        end else begin
            slot_out = slot_in;
            use_exp  = 1'b0;
        end
    end

endmodule

// File: rtl/strobe_steer.sv
module strobe_steer (
    input  logic clk,
    input  logic rst,
    input  logic cas_in,
    input  logic want_exp,
    output logic cas_base,
    output logic cas_exp
);

    logic active_q;
    logic sel_q;
    logic pick_exp;

    always_ff @(posedge clk) begin
        if (rst) begin
            active_q <= 1'b0;
            sel_q    <= 1'b0;
        end else begin
            active_q <= cas_in;
            if (cas_in && !active_q) sel_q <= want_exp;
        end
    end

    assign pick_exp = active_q ? sel_q : want_exp;
    assign cas_exp  = cas_in && pick_exp;
    assign cas_base = cas_in && !pick_exp;

    AST_ONE_STROBE: assert property (@(posedge clk) disable iff (rst)
        cas_in |-> ($countones({cas_base, cas_exp}) == 1)); // R11
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
        !cas_in |-> (!cas_base && !cas_exp)); // R11
    AST_EXP_HELD: assert property (@(posedge clk) disable iff (rst)
        cas_exp |=> (!cas_in || cas_exp)); // R12
    AST_BASE_HELD: assert property (@(posedge clk) disable iff (rst)
        cas_base |=> (!cas_in || cas_base)); // R12

endmodule

// File: rtl/ram_bank_mapper.sv
module ram_bank_mapper
    import ram_map_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              cpu_a15,
    input  logic              cpu_a14,
    input  logic [DATA_W-1:0] data_in,
    input  logic              io_wr,
    input  logic              cpu_cycle,
    input  logic              ram_dis,
    input  logic              cas_in,
    output logic              map_a15,
    output logic              map_a14,
    output logic              cas_base,
    output logic              cas_exp
);

    map_code_t code;
    slot_t     slot_out;
    logic      use_exp;

    map_code_reg u_code (
        .clk     (clk),
        .rst     (rst),
        .io_wr   (io_wr),
        .cpu_a15 (cpu_a15),
        .data_in (data_in),
        .code    (code)
    );

    slot_remap u_remap (
        .cpu_cycle (cpu_cycle),
        .slot_in   ({cpu_a15, cpu_a14}),
        .code      (code),
        .slot_out  (slot_out),
        .use_exp   (use_exp)
    );

    strobe_steer u_steer (
        .clk      (clk),
        .rst      (rst),
        .cas_in   (cas_in),
        .want_exp (use_exp && !ram_dis),
        .cas_base (cas_base),
        .cas_exp  (cas_exp)
    );

    assign map_a15 = slot_out[1];
    assign map_a14 = slot_out[0];

    AST_VIDEO_PASS: assert property (@(posedge clk) disable iff (rst)
        !cpu_cycle |-> (map_a15 == cpu_a15 && map_a14 == cpu_a14)); // R9
    AST_VIDEO_BASE: assert property (@(posedge clk) disable iff (rst)
        (cas_in && !$past(cas_in) && !cpu_cycle) |-> !cas_exp); // R9
    AST_DIS_BASE: assert property (@(posedge clk) disable iff (rst)
        (cas_in && !$past(cas_in) && ram_dis) |-> !cas_exp); // R10

endmodule

// File: tb/ram_bank_mapper_test.sv
module ram_bank_mapper_test;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       cpu_a15 = 1'b0, cpu_a14 = 1'b0;
    logic [7:0] data_in = 8'h00;
    logic       io_wr = 1'b0, cpu_cycle = 1'b0, ram_dis = 1'b0, cas_in = 1'b0;
    logic       map_a15, map_a14, cas_base, cas_exp;

    int    checks = 0;
    int    errors = 0;
    bit    done = 1'b0;
    string tag = "R3";

    int m_code = 0;
    bit m_active = 1'b0;
    bit m_sel = 1'b0;

    always #5 clk = ~clk;

    ram_bank_mapper uut (
        .clk(clk), .rst(rst), .cpu_a15(cpu_a15), .cpu_a14(cpu_a14),
        .data_in(data_in), .io_wr(io_wr), .cpu_cycle(cpu_cycle),
        .ram_dis(ram_dis), .cas_in(cas_in), .map_a15(map_a15),
        .map_a14(map_a14), .cas_base(cas_base), .cas_exp(cas_exp)
    );

    // Returns bank*2 + expansion flag, straight from the mapping rules.
    function automatic int ref_map(input int code, input int slot);
        int bank = slot;
        int ex = 0;
        if (code >= 4) begin
            if (slot == 1) begin ex = 1; bank = code % 4; end
        end else if (code == 1) begin
            ex = (slot == 3) ? 1 : 0;
        end else if (code == 2) begin
            ex = 1;
        end else if (code == 3) begin
            if (slot == 1) bank = 3;
            ex = (slot == 3) ? 1 : 0;
        end
        return bank * 2 + ex;
    endfunction

    function automatic bit want_now();
        int slot = {30'd0, cpu_a15, cpu_a14};
        return cpu_cycle && (ref_map(m_code, slot) % 2 == 1) && !ram_dis;
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            m_code <= 0; m_active <= 1'b0; m_sel <= 1'b0;
        end else begin
            if (cas_in && !m_active) m_sel <= want_now();
            m_active <= cas_in;
            if (io_wr && !cpu_a15 && data_in[7] && data_in[6]) m_code <= int'(data_in[2:0]);
        end
    end

    always @(negedge clk) begin
        if (!rst && !done) begin
            int slot;
            int e_addr;
            bit e_exp;
            bit e_base;
            slot = {30'd0, cpu_a15, cpu_a14};
            e_addr = cpu_cycle ? ref_map(m_code, slot) / 2 : slot;
            e_exp = cas_in && (m_active ? m_sel : want_now());
            e_base = cas_in && !e_exp;
            checks++;
            if ({map_a15, map_a14} != e_addr[1:0] || cas_exp != e_exp || cas_base != e_base) begin
                errors++;
                $display("FAIL %s: code=%0d slot=%0d got addr=%0d base=%0b exp=%0b, expected addr=%0d base=%0b exp=%0b",
                         tag, m_code, slot, {map_a15, map_a14}, cas_base, cas_exp, e_addr, e_base, e_exp);
            end
        end
    end

    task automatic step();
        @(negedge clk); #1;
    endtask

    task automatic write_port(input logic [7:0] d, input logic a15, input logic wr);
        step();
        data_in = d; cpu_a15 = a15; cpu_a14 = 1'b1; io_wr = wr; cpu_cycle = 1'b0; cas_in = 1'b0;
        step();
        io_wr = 1'b0; data_in = 8'h00;
    endtask

    task automatic access(input int slot, input bit cpu, input bit dis);
        cpu_a15 = slot[1]; cpu_a14 = slot[0]; cpu_cycle = cpu; ram_dis = dis; cas_in = 1'b1;
        step();
        step();
        cas_in = 1'b0;
        step();
    endtask

    task automatic sweep(input bit cpu, input bit dis);
        for (int s = 0; s < 4; s++) access(s, cpu, dis);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        step();
        rst = 1'b0;
        tag = "R3";
        sweep(1'b1, 1'b0);

        for (int c = 0; c < 8; c++) begin
            write_port({2'b11, 3'b010, c[2:0]}, 1'b0, 1'b1);
            tag = (c == 0) ? "R3" : (c == 1) ? "R4" : (c == 2) ? "R5" : (c == 3) ? "R6" : "R7";
            sweep(1'b1, 1'b0);
            tag = "R10";
            sweep(1'b1, 1'b1);
            tag = "R9";
            sweep(1'b0, 1'b0);
        end

        tag = "R1";
        write_port(8'hEA, 1'b0, 1'b1);
        sweep(1'b1, 1'b0);
        write_port(8'hF9, 1'b0, 1'b1);
        sweep(1'b1, 1'b0);

        tag = "R2";
        write_port(8'hC2, 1'b0, 1'b0);
        sweep(1'b1, 1'b0);
        write_port(8'hC2, 1'b1, 1'b1);
        sweep(1'b1, 1'b0);
        write_port(8'h82, 1'b0, 1'b1);
        sweep(1'b1, 1'b0);
        write_port(8'h42, 1'b0, 1'b1);
        sweep(1'b1, 1'b0);

        tag = "R8";
        write_port(8'hC3, 1'b0, 1'b1);
        cpu_cycle = 1'b1;
        for (int i = 0; i < 12; i++) begin
            cpu_a15 = i[0]; cpu_a14 = i[1] ^ i[2];
            step();
        end

        tag = "R12";
        write_port(8'hC2, 1'b0, 1'b1);
        cpu_a15 = 1'b0; cpu_a14 = 1'b1; cpu_cycle = 1'b1; ram_dis = 1'b0; cas_in = 1'b1;
        step();
        ram_dis = 1'b1; step();
        cpu_cycle = 1'b0; step();
        cas_in = 1'b0; step();
        ram_dis = 1'b1; cpu_cycle = 1'b1; cas_in = 1'b1;
        step();
        ram_dis = 1'b0; step();
        cpu_a15 = 1'b1; step();
        cas_in = 1'b0; ram_dis = 1'b0; step();

        tag = "R11";
        for (int i = 0; i < 10; i++) begin
            cas_in = i[0] | i[2]; cpu_a15 = i[1]; cpu_a14 = i[0]; ram_dis = (i == 6);
            step();
        end
        cas_in = 1'b0;

        tag = "R3";
        write_port(8'hC2, 1'b0, 1'b1);
        rst = 1'b1;
        step();
        rst = 1'b0;
        sweep(1'b1, 1'b0);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            errors++;
            $display("FAIL watchdog: got no completion, expected completion within 20000 cycles");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule